// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits in a root port and takes in error messages that devices below the port have reported. Each message carries a severity (correctable, nonfatal or fatal) and a 16-bit requester ID. The block keeps a root error status register. It records whether each class has been received once or more than once. On the first message of a class it captures the requester ID: correctable sources go to one field and uncorrectable sources to another.

A three-bit root command register holds one interrupt enable per severity. The block raises the advanced-error interrupt in one of three ways, in this priority: a one-cycle MSI-X pulse, then a one-cycle MSI pulse, then a level INTx. Message interrupts fire only on a false-to-true change of the enabled-pending condition. Software clears status by writing ones. A read-only interrupt message number is loaded from a device-side input.

The message input is a valid/ready stream. `msg_ready` is held high, so the block never applies back-pressure. A message is taken on every cycle in which `msg_valid` is high.

Top module: `root_err_collector`

## Requirements
- R1: Correctable message (msg_sev=0): if status bit 0 (correctable received) is already set, set bit 1 (multiple correctable). Otherwise load msg_src into cor_src. Then set bit 0.
- R2: Fatal message (msg_sev=2): set bit 4 (first uncorrectable is fatal) if bit 2 was clear, then set bit 6 (fatal received). Nonfatal message (msg_sev=1): set bit 5 (nonfatal received).
- R3: Nonfatal or fatal message: if bit 2 (uncorrectable received) is already set, set bit 3 (multiple uncorrectable). Otherwise load msg_src into uncor_src. Then set bit 2.
- R4: When sts_w1c is high, each status bit with a one in sts_wdata is cleared. Writing bit 0 zeroes cor_src, and writing bit 2 zeroes uncor_src. A message accepted in the same cycle is applied after the clear.
- R5: When cmd_wr is high, root_cmd loads cmd_wdata. The bit order is bit0 correctable enable, bit1 nonfatal enable, bit2 fatal enable.
- R6: The pending condition is the OR of (bit0 & cmd0), (bit5 & cmd1) and (bit6 & cmd2). A message or a command write that turns the condition from false to true produces one interrupt pulse, one cycle after the accepting edge. No pulse occurs when the condition was already true.
- R7: A command write that leaves the condition false, or finds it already true, gives no pulse. A status clear alone never gives a pulse.
- R8: When msix_en is high, pulses go to msix_pulse. When msix_en is low and msi_en is high, they go to msi_pulse. When both are low, no pulse is produced.
- R9: With msix_en and msi_en both low, intx_level equals the pending condition. Otherwise intx_level is 0.
- R10: int_msg_num loads vec_in when vec_load is high. Software has no path to change it.
- R11: msg_ready is always 1. A message with msg_sev=3 changes no state and produces no pulse.
- R12: Reset clears the status, both source fields, root_cmd, int_msg_num and all interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message valid |
| msg_ready | output | 1 | Always 1 |
| msg_sev | input | 2 | 0 correctable, 1 nonfatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Requester ID |
| cmd_wr | input | 1 | Root command write strobe |
| cmd_wdata | input | 3 | Command enables |
| sts_w1c | input | 1 | Status clear strobe |
| sts_wdata | input | 7 | Ones clear the matching status bits |
| msix_en | input | 1 | MSI-X delivery active |
| msi_en | input | 1 | MSI delivery active |
| vec_load | input | 1 | Load interrupt message number |
| vec_in | input | 5 | Interrupt message number from the device side |
| root_cmd | output | 3 | Root command register |
| root_sts | output | 7 | Root error status bits |
| int_msg_num | output | 5 | Interrupt message number |
| cor_src | output | 16 | First correctable source ID |
| uncor_src | output | 16 | First uncorrectable source ID |
| msix_pulse | output | 1 | MSI-X request pulse |
| msi_pulse | output | 1 | MSI request pulse |
| intx_level | output | 1 | INTx level |

## Verification
The bench fires repeated messages of the same class and checks that later messages do not overwrite the captured source IDs; a design that captured on every message would show the newest ID instead. It sends a fatal message after a nonfatal one, where a wrong design would still set the first-fatal bit, and a nonfatal message while a fatal one is pending, where a level-minded design would pulse again. It also clears status in the same cycle as a message, switches the delivery modes while errors are pending, and issues command writes that enable an already-pending class, so that a misplaced clear order, a wrong MSI-X/MSI priority or a missing edge detector shows up as a wrong bit or a spurious pulse.

// File: rtl/rerr_pkg.sv
package rerr_pkg;
  localparam int STS_W = 7;
  localparam int CMD_W = 3;
  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NONF  = 2'd1,
    SEV_FATAL = 2'd2,
    SEV_NONE  = 2'd3
  } sev_e;
  localparam int B_COR    = 0;
  localparam int B_MCOR   = 1;
  localparam int B_UNC    = 2;
  localparam int B_MUNC   = 3;
  localparam int B_FFATAL = 4;
  localparam int B_NONF   = 5;
  localparam int B_FATAL  = 6;

  function automatic logic pend_of(input logic [STS_W-1:0] s, input logic [CMD_W-1:0] c);
    return (s[B_COR] & c[0]) | (s[B_NONF] & c[1]) | (s[B_FATAL] & c[2]);
  endfunction
endpackage

// File: rtl/rerr_status.sv
module rerr_status
  import rerr_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [1:0]       sev,
  input  logic [SRC_W-1:0] src,
  input  logic             w1c,
  input  logic [STS_W-1:0] w1c_data,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] sts_d,
  output logic [SRC_W-1:0] cor_src_q,
  output logic [SRC_W-1:0] unc_src_q
);
  logic [STS_W-1:0] clr;
  logic [SRC_W-1:0] cor_d, unc_d;
  logic             is_unc;

  assign clr    = w1c ? w1c_data : '0;
  assign is_unc = (sev == SEV_NONF) || (sev == SEV_FATAL);

  always_comb begin
    sts_d = sts_q & ~clr;
    cor_d = clr[B_COR] ? '0 : cor_src_q;
    unc_d = clr[B_UNC] ? '0 : unc_src_q;
    if (take && sev == SEV_COR) begin
      if (sts_d[B_COR]) sts_d[B_MCOR] = 1'b1;
      else              cor_d = src;
      sts_d[B_COR] = 1'b1;
    end
    if (take && sev == SEV_FATAL) begin
      if (!sts_d[B_UNC]) sts_d[B_FFATAL] = 1'b1;
      sts_d[B_FATAL] = 1'b1;
    end
    if (take && sev == SEV_NONF) sts_d[B_NONF] = 1'b1;
    if (take && is_unc) begin
      if (sts_d[B_UNC]) sts_d[B_MUNC] = 1'b1;
      else              unc_d = src;
      sts_d[B_UNC] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q     <= '0;
      cor_src_q <= '0;
      unc_src_q <= '0;
    end else begin
      sts_q     <= sts_d;
      cor_src_q <= cor_d;
      unc_src_q <= unc_d;
    end
  end

  // R1
  cor_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[B_COR] && !(w1c && w1c_data[B_COR])) |=> $stable(cor_src_q));
  // R3
  unc_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[B_UNC] && !(w1c && w1c_data[B_UNC])) |=> $stable(unc_src_q));
endmodule

// File: rtl/rerr_cmd.sv
module rerr_cmd
  import rerr_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  input  logic             vload,
  input  logic [VEC_W-1:0] vin,
  output logic [CMD_W-1:0] cmd_q,
  output logic [CMD_W-1:0] cmd_d,
  output logic [VEC_W-1:0] vec_q
);
  assign cmd_d = wr ? wdata : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      vec_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      if (vload) vec_q <= vin;
    end
  end

  // R10
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vload) |-> $stable(vec_q));
endmodule

// File: rtl/rerr_irq.sv
module rerr_irq
  import rerr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic [STS_W-1:0] sts_q,
  input  logic [STS_W-1:0] sts_d,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [CMD_W-1:0] cmd_d,
  input  logic             msix_en,
  input  logic             msi_en,
  output logic             msix_pulse,
  output logic             msi_pulse,
  output logic             intx_level
);
  logic pend_now, pend_next, fire;

  assign pend_now  = pend_of(sts_q, cmd_q);
  assign pend_next = pend_of(sts_d, cmd_d);
  assign fire      = event_in && pend_next && !pend_now;
  assign intx_level = !msix_en && !msi_en && pend_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msix_pulse <= 1'b0;
      msi_pulse  <= 1'b0;
    end else begin
      msix_pulse <= fire && msix_en;
      msi_pulse  <= fire && !msix_en && msi_en;
    end
  end

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msix_pulse, msi_pulse}));
  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == 1'b0) |=> !(msix_pulse || msi_pulse));
  // R9
  intx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_level |-> (!msix_en && !msi_en));
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rerr_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             sts_w1c,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic             vec_load,
  input  logic [VEC_W-1:0] vec_in,
  output logic [CMD_W-1:0] root_cmd,
  output logic [STS_W-1:0] root_sts,
  output logic [VEC_W-1:0] int_msg_num,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] uncor_src,
  output logic             msix_pulse,
  output logic             msi_pulse,
  output logic             intx_level
);
  logic             take;
  logic [STS_W-1:0] sts_d;
  logic [CMD_W-1:0] cmd_d;

  assign msg_ready = 1'b1;
  assign take      = msg_valid && msg_ready && (msg_sev != SEV_NONE);

  rerr_status #(.SRC_W(SRC_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .take(take), .sev(msg_sev), .src(msg_src),
    .w1c(sts_w1c), .w1c_data(sts_wdata), .sts_q(root_sts), .sts_d(sts_d),
    .cor_src_q(cor_src), .unc_src_q(uncor_src)
  );

  rerr_cmd #(.VEC_W(VEC_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_wdata),
    .vload(vec_load), .vin(vec_in), .cmd_q(root_cmd), .cmd_d(cmd_d),
    .vec_q(int_msg_num)
  );

  rerr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .event_in(take || cmd_wr),
    .sts_q(root_sts), .sts_d(sts_d), .cmd_q(root_cmd), .cmd_d(cmd_d),
    .msix_en(msix_en), .msi_en(msi_en), .msix_pulse(msix_pulse),
    .msi_pulse(msi_pulse), .intx_level(intx_level)
  );

  // R11
  ignored_sev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_NONE && !sts_w1c) |=> $stable(root_sts));
endmodule

// File: tb/sim_root_err_collector.sv
module sim_root_err_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 0, cmd_wr = 0, sts_w1c = 0, msix_en = 0, msi_en = 0, vec_load = 0;
  logic [1:0] msg_sev = 0;
  logic [15:0] msg_src = 0;
  logic [2:0] cmd_wdata = 0;
  logic [6:0] sts_wdata = 0;
  logic [4:0] vec_in = 0;
  logic msg_ready, msix_pulse, msi_pulse, intx_level;
  logic [2:0] root_cmd;
  logic [6:0] root_sts;
  logic [4:0] int_msg_num;
  logic [15:0] cor_src, uncor_src;

  int checks = 0, errors = 0;
  logic [6:0] m_sts = 0;
  logic [15:0] m_cs = 0, m_us = 0;
  logic [2:0] m_cmd = 0;
  logic [4:0] m_vec = 0;
  logic m_x = 0, m_m = 0;

  always #2 clk = ~clk;

  root_err_collector u0 (.*);

  function automatic logic pend(input logic [6:0] s, input logic [2:0] c);
    return (s[0] & c[0]) | (s[5] & c[1]) | (s[6] & c[2]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 R2 R3 R4 R11 root_sts", 32'(root_sts), 32'(m_sts));
    chk("R1 R4 cor_src", 32'(cor_src), 32'(m_cs));
    chk("R3 R4 uncor_src", 32'(uncor_src), 32'(m_us));
    chk("R5 root_cmd", 32'(root_cmd), 32'(m_cmd));
    chk("R10 int_msg_num", 32'(int_msg_num), 32'(m_vec));
    chk("R6 R7 R8 msix_pulse", 32'(msix_pulse), 32'(m_x));
    chk("R6 R7 R8 msi_pulse", 32'(msi_pulse), 32'(m_m));
    chk("R9 intx_level", 32'(intx_level), 32'(!msix_en && !msi_en && pend(m_sts, m_cmd)));
    chk("R11 msg_ready", 32'(msg_ready), 32'd1);
  endtask

  // model the edge that follows the inputs currently driven
  task automatic model_step();
    logic [6:0] n;
    logic [15:0] cs, us;
    logic [2:0] c;
    logic tk, fire;
    n = m_sts & ~(sts_w1c ? sts_wdata : 7'd0);
    cs = (sts_w1c && sts_wdata[0]) ? 16'd0 : m_cs;
    us = (sts_w1c && sts_wdata[2]) ? 16'd0 : m_us;
    tk = msg_valid && msg_sev != 2'd3;
    if (tk && msg_sev == 2'd0) begin
      if (n[0]) n[1] = 1; else cs = msg_src;
      n[0] = 1;
    end
    if (tk && msg_sev != 2'd0) begin
      if (msg_sev == 2'd2) begin
        if (!n[2]) n[4] = 1;
        n[6] = 1;
      end else n[5] = 1;
      if (n[2]) n[3] = 1; else us = msg_src;
      n[2] = 1;
    end
    c = cmd_wr ? cmd_wdata : m_cmd;
    fire = (tk || cmd_wr) && pend(n, c) && !pend(m_sts, m_cmd);
    m_x = fire && msix_en;
    m_m = fire && !msix_en && msi_en;
    m_sts = n; m_cs = cs; m_us = us; m_cmd = c;
    if (vec_load) m_vec = vec_in;
  endtask

  task automatic idle_in();
    msg_valid = 0; cmd_wr = 0; sts_w1c = 0; vec_load = 0;
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    check_all();
    idle_in();
  endtask

  task automatic send(input logic [1:0] s, input logic [15:0] id);
    msg_valid = 1; msg_sev = s; msg_src = id; cycle();
  endtask

  task automatic wcmd(input logic [2:0] v);
    cmd_wr = 1; cmd_wdata = v; cycle();
  endtask

  task automatic clr(input logic [6:0] v);
    sts_w1c = 1; sts_wdata = v; cycle();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check_all();
    chk("R12 reset sts", 32'(root_sts), 32'd0);

    // directed: MSI, repeated correctable keeps first source (R1, R6)
    msi_en = 1;
    wcmd(3'b111);
    send(2'd0, 16'hAAAA);
    chk("R6 msi fired", 32'(msi_pulse), 32'd1);
    send(2'd0, 16'hBBBB);
    chk("R1 first cor src kept", 32'(cor_src), 32'hAAAA);
    // nonfatal then fatal: no first-fatal, no second pulse (R2, R6)
    send(2'd1, 16'h1111);
    send(2'd2, 16'h2222);
    chk("R2 first fatal clear", 32'(root_sts[4]), 32'd0);
    chk("R6 no repeat pulse", 32'(msi_pulse), 32'd0);
    chk("R3 uncor src first", 32'(uncor_src), 32'h1111);
    // clear all, same-cycle message applied after clear (R4)
    sts_w1c = 1; sts_wdata = 7'h7f; msg_valid = 1; msg_sev = 2'd2; msg_src = 16'h3333; cycle();
    chk("R4 clear then fatal", 32'(root_sts), 32'h54);
    clr(7'h7f);
    // cmd write enabling pending class fires once (R7), msix priority (R8)
    wcmd(3'b000);
    send(2'd0, 16'h0C0C);
    msix_en = 1;
    wcmd(3'b001);
    chk("R7 R8 cmd edge msix", 32'(msix_pulse), 32'd1);
    wcmd(3'b011);
    chk("R7 no pulse when already true", 32'(msix_pulse), 32'd0);
    msix_en = 0; msi_en = 0;
    @(negedge clk);
    chk("R9 intx level", 32'(intx_level), 32'd1);
    // ignored severity (R11), vector load (R10)
    send(2'd3, 16'hDEAD);
    vec_load = 1; vec_in = 5'd19; cycle();
    chk("R10 vector", 32'(int_msg_num), 32'd19);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      msg_valid = ($urandom % 3) == 0;
      msg_sev   = 2'($urandom);
      msg_src   = 16'($urandom);
      cmd_wr    = ($urandom % 6) == 0;
      cmd_wdata = 3'($urandom);
      sts_w1c   = ($urandom % 7) == 0;
      sts_wdata = 7'($urandom);
      vec_load  = ($urandom % 20) == 0;
      vec_in    = 5'($urandom);
      if (($urandom % 30) == 0) begin
        msix_en = 1'($urandom);
        msi_en  = 1'($urandom);
      end
      cycle();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule